// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps one byte of state that tells firmware why the device came out of its last reset and what power state it was in. Hardware strobes from the reset and power-management logic update the flags: a power-on event, a brown-out event, a watchdog expiry, a reset instruction, a sleep instruction and a watchdog-clear instruction. Each flag responds to its own set of events. Some are cleared only by hardware and raised again only by firmware. Others are driven both ways by hardware and cannot be written from the bus.

Firmware reads the byte on `rd_data` and writes it through a one-cycle write strobe. Bit 7 holds a plain read/write interrupt priority enable for an external interrupt controller. When the on-chip regulator is off (`reg_en` low), the brown-out flag reads 0 and is held at 0 in storage. Software identifies a brown-out as bit 0 at 0 while bit 1 is at 1, assuming it set bit 1 after the previous power-on.

Top module: `reset_cause_reg`

## Requirements
- R1: After `rst_n` is low, and one cycle after a `por_evt` strobe, `rd_data` is 8'h1C: bit 7 priority enable 0, bit 4 reset-instruction flag 1, bit 3 time-out flag 1, bit 2 power-down flag 1, bit 1 power-on flag 0, bit 0 brown-out flag 0. `por_evt` overrides every other input in its cycle.
- R2: Bits 6 and 5 of `rd_data` always read 0, and writing 1 to them has no effect.
- R3: A cycle with `wr_en` high loads bits 7, 4, 1 and 0 from `wr_data`. Bits 3 and 2 ignore bus writes.
- R4: `wdt_to_evt` clears bit 3. `sleep_evt` or `wdt_clr_evt` sets bit 3. If both happen in the same cycle, the expiry wins.
- R5: `sleep_evt` clears bit 2 and `wdt_clr_evt` sets it. If both happen in the same cycle, sleep wins.
- R6: `rst_instr_evt` clears bit 4. Only a bus write or a power-on event sets it again.
- R7: `bor_evt` clears bit 0 and leaves every other bit as it was.
- R8: When a hardware event and a bus write target the same bit in one cycle, the hardware event wins. The write still updates the other writable bits.
- R9: While `reg_en` is low, bit 0 reads 0 and writes of 1 to it are lost. After `reg_en` returns high, it stays 0 until firmware writes 1.
- R10: Every change caused by a strobe or a write appears on `rd_data` in the cycle after the clock edge that samples it. A change of `reg_en` reaches bit 0 of `rd_data` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| por_evt | input | 1 | Power-on event strobe |
| bor_evt | input | 1 | Brown-out event strobe |
| wdt_to_evt | input | 1 | Watchdog expiry strobe |
| rst_instr_evt | input | 1 | Reset instruction strobe |
| sleep_evt | input | 1 | Sleep instruction strobe |
| wdt_clr_evt | input | 1 | Watchdog-clear instruction strobe |
| reg_en | input | 1 | On-chip regulator enabled |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Register readback |

## Verification
Every strobe or write that the clock edge samples shows up on `rd_data` one edge later. The bench therefore drives inputs at a falling edge, lets one rising edge pass, clears the strobes and compares at the next falling edge. `reg_en` acts on bit 0 of the readback without any register in between, so the comparison uses the `reg_en` value present at that falling edge. The behavioural model updates once per rising edge, so every compare lines up with the single register stage in the design.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int unsigned REG_W = 8;

    localparam int unsigned BIT_PRIO = 7;
    localparam int unsigned BIT_RI   = 4;
    localparam int unsigned BIT_TO   = 3;
    localparam int unsigned BIT_PD   = 2;
    localparam int unsigned BIT_POR  = 1;
    localparam int unsigned BIT_BOR  = 0;

    localparam logic [REG_W-1:0] RESET_VAL = (REG_W'(1) << BIT_RI) | (REG_W'(1) << BIT_TO)
                                           | (REG_W'(1) << BIT_PD);
    localparam logic [REG_W-1:0] WR_MASK   = (REG_W'(1) << BIT_PRIO) | (REG_W'(1) << BIT_RI)
                                           | (REG_W'(1) << BIT_POR) | (REG_W'(1) << BIT_BOR);
    localparam logic [REG_W-1:0] IMPL_MASK = WR_MASK | (REG_W'(1) << BIT_TO) | (REG_W'(1) << BIT_PD);

    typedef struct packed {
        logic por;
        logic bor;
        logic wdt_to;
        logic rst_instr;
        logic sleep;
        logic wdt_clr;
    } rcause_evt_t;

    typedef struct packed {
        logic [REG_W-1:0] set;
        logic [REG_W-1:0] clr;
    } rcause_mask_t;

endpackage

// File: rtl/rcause_event_decode.sv
module rcause_event_decode
    import rcause_pkg::*;
(
    input  rcause_evt_t  evt,
    output rcause_mask_t mask
);

    always_comb begin
        mask = '0;
        if (evt.por) begin
            mask.set = RESET_VAL;
            mask.clr = ~RESET_VAL;
        end else begin
            if (evt.bor)       mask.clr[BIT_BOR] = 1'b1;
            if (evt.rst_instr) mask.clr[BIT_RI]  = 1'b1;
            if (evt.wdt_to) begin
                mask.clr[BIT_TO] = 1'b1;
            end else if (evt.sleep || evt.wdt_clr) begin
                mask.set[BIT_TO] = 1'b1;
            end
            if (evt.sleep) begin
                mask.clr[BIT_PD] = 1'b1;
            end else if (evt.wdt_clr) begin
                mask.set[BIT_PD] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rcause_flag_bit.sv
module rcause_flag_bit #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic force_clr,
    input  logic wr_en,
    input  logic wr_val,
    output logic flag
);

    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (wr_en)  flag_d = wr_val;
        if (hw_set) flag_d = 1'b1;
        if (hw_clr) flag_d = 1'b0;
        if (force_clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RESET_VAL;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
    import rcause_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_evt,
    input  logic             bor_evt,
    input  logic             wdt_to_evt,
    input  logic             rst_instr_evt,
    input  logic             sleep_evt,
    input  logic             wdt_clr_evt,
    input  logic             reg_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);

    rcause_evt_t      evt;
    rcause_mask_t     mask;
    logic [REG_W-1:0] flags;
    logic [REG_W-1:0] force_vec;
    logic [REG_W-1:0] bor_keep;

    always_comb begin
        evt.por       = por_evt;
        evt.bor       = bor_evt;
        evt.wdt_to    = wdt_to_evt;
        evt.rst_instr = rst_instr_evt;
        evt.sleep     = sleep_evt;
        evt.wdt_clr   = wdt_clr_evt;
        force_vec          = '0;
        force_vec[BIT_BOR] = ~reg_en;
        bor_keep           = '1;
        bor_keep[BIT_BOR]  = reg_en;
    end

    rcause_event_decode i_decode (
        .evt  (evt),
        .mask (mask)
    );

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        rcause_flag_bit #(
            .RESET_VAL (RESET_VAL[i])
        ) i_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .hw_set    (mask.set[i] & IMPL_MASK[i]),
            .hw_clr    (mask.clr[i]),
            .force_clr (force_vec[i]),
            .wr_en     (wr_en & WR_MASK[i]),
            .wr_val    (wr_data[i]),
            .flag      (flags[i])
        );
    end

    assign rd_data = flags & IMPL_MASK & bor_keep;

endmodule

// File: rtl/reset_cause_reg_chk.sv
module reset_cause_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_evt,
    input logic       bor_evt,
    input logic       wdt_to_evt,
    input logic       rst_instr_evt,
    input logic       sleep_evt,
    input logic       wdt_clr_evt,
    input logic       reg_en,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data
);

    logic any_evt;
    assign any_evt = por_evt | bor_evt | wdt_to_evt | rst_instr_evt | sleep_evt | wdt_clr_evt;

    AST_POR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> rd_data == 8'h1C) else $error("por load");  // R1

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6:5] == 2'b00) else $error("unimpl bits");  // R2

    AST_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_evt) |=> $stable(rd_data[3:2])) else $error("read-only bits");  // R3

    AST_TO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_to_evt && !por_evt) |=> !rd_data[3]) else $error("timeout flag");  // R4

    AST_PD_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_evt && !por_evt) |=> !rd_data[2]) else $error("sleep pd");  // R5

    AST_PD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr_evt && !sleep_evt && !por_evt) |=> rd_data[2]) else $error("clr pd");  // R5

    AST_RI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_instr_evt && !por_evt) |=> !rd_data[4]) else $error("reset instr");  // R6

    AST_BOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bor_evt |=> !rd_data[0]) else $error("brownout");  // R7

    AST_REG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> !rd_data[0]) else $error("regulator off");  // R9

endmodule

bind reset_cause_reg reset_cause_reg_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_evt       (por_evt),
    .bor_evt       (bor_evt),
    .wdt_to_evt    (wdt_to_evt),
    .rst_instr_evt (rst_instr_evt),
    .sleep_evt     (sleep_evt),
    .wdt_clr_evt   (wdt_clr_evt),
    .reg_en        (reg_en),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data)
);

// File: tb/test_reset_cause_reg.sv
`timescale 1ns/1ps
module test_reset_cause_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_evt = 1'b0, bor_evt = 1'b0, wdt_to_evt = 1'b0;
    logic       rst_instr_evt = 1'b0, sleep_evt = 1'b0, wdt_clr_evt = 1'b0;
    logic       reg_en = 1'b1, wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model = 8'h1C;

    always #2 clk = ~clk;

    reset_cause_reg i_reset_cause_reg (
        .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bor_evt(bor_evt),
        .wdt_to_evt(wdt_to_evt), .rst_instr_evt(rst_instr_evt), .sleep_evt(sleep_evt),
        .wdt_clr_evt(wdt_clr_evt), .reg_en(reg_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] expect_rd();
        logic [7:0] v = model & 8'h9F;
        if (!reg_en) v[0] = 1'b0;
        return v;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (rd_data !== expect_rd()) begin
            errors++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, expect_rd());
        end
    endtask

    // Reference update: later statements override earlier ones.
    task automatic model_edge(input logic p, b, t, ri, s, c, w, input logic [7:0] d, input logic re);
        if (p) begin
            model = 8'h1C;
        end else begin
            if (w) begin
                model[7] = d[7]; model[4] = d[4]; model[1] = d[1]; model[0] = d[0];
            end
            if (s || c) model[3] = 1'b1;
            if (c) model[2] = 1'b1;
            if (s) model[2] = 1'b0;
            if (t) model[3] = 1'b0;
            if (ri) model[4] = 1'b0;
            if (b) model[0] = 1'b0;
        end
        if (!re) model[0] = 1'b0;
    endtask

    task automatic step(input logic p, b, t, ri, s, c, w, input logic [7:0] d,
                        input logic re, input string tag);
        por_evt = p; bor_evt = b; wdt_to_evt = t; rst_instr_evt = ri;
        sleep_evt = s; wdt_clr_evt = c; wr_en = w; wr_data = d; reg_en = re;
        @(posedge clk);
        model_edge(p, b, t, ri, s, c, w, d, re);
        @(negedge clk);
        por_evt = 0; bor_evt = 0; wdt_to_evt = 0; rst_instr_evt = 0;
        sleep_evt = 0; wdt_clr_evt = 0; wr_en = 0;
        check(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: rd_data=%02h expected=done", rd_data);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle");
        // p b t ri s c w data re
        step(0,0,0,0,0,0,1,8'hFF,1,"R2 R3 write all ones");     // 9F
        step(0,0,0,0,0,0,1,8'h00,1,"R3 write zeros");           // 0C
        step(0,0,0,0,0,0,1,8'h93,1,"R3 set sticky");            // 9F
        step(0,0,1,0,0,0,0,8'h00,1,"R4 expiry");                 // 97
        step(0,0,0,0,0,1,0,8'h00,1,"R4 clr sets to");
        step(0,0,0,0,1,0,0,8'h00,1,"R5 sleep");
        step(0,0,0,0,0,1,0,8'h00,1,"R5 clr sets pd");
        step(0,0,1,0,1,0,0,8'h00,1,"R4 expiry beats sleep");
        step(0,0,0,0,1,1,0,8'h00,1,"R5 sleep beats clr");
        step(0,0,0,1,0,0,0,8'h00,1,"R6 reset instr");
        step(0,0,0,0,0,0,0,8'h00,1,"R6 stays clear");
        step(0,0,0,0,0,0,1,8'h10,1,"R6 write restores");
        step(0,0,0,0,0,0,1,8'h13,1,"R7 prep");
        step(0,1,0,0,0,0,0,8'h00,1,"R7 brownout");
        step(0,0,0,0,0,0,1,8'h13,1,"R8 write");
        step(0,1,0,0,0,0,1,8'h93,1,"R8 write with brownout");
        step(0,0,0,1,0,0,1,8'h10,1,"R8 write with reset instr");
        step(0,0,0,0,0,0,1,8'h01,1,"R9 prep");
        step(0,0,0,0,0,0,0,8'h00,0,"R9 regulator off");
        step(0,0,0,0,0,0,1,8'h01,0,"R9 write lost");
        step(0,0,0,0,0,0,0,8'h00,1,"R9 stays zero");
        step(0,0,0,0,0,0,1,8'h01,1,"R9 write after enable");
        step(1,0,1,1,0,1,1,8'hFF,1,"R1 por event overrides");
        for (int k = 0; k < 400; k++) begin
            logic [15:0] r = 16'($urandom);
            step(r[0] & r[1] & r[2], r[3], r[4], r[5], r[6], r[7], r[8],
                 8'($urandom), ~(r[9] & r[10]), "R10 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule